// File: doc/BRIEF.md
# Quadrature position and revolution counter

This block turns the three signals of a rotary encoder (two phase-shifted tracks and an index pulse) into a signed-free position count and a revolution count. Each of the three pins crosses into the clock domain through a two-flop synchroniser. A transition on one track is then classified by the phase relationship of the two tracks, which yields one step up or down. The index input returns the position count to zero and advances or retreats the revolution count by one. A second operating mode treats the two tracks as independent count-up and count-down strobes.

Every input has its own two-bit edge selector, so the host can count on rising edges, falling edges, both or neither. That choice gives, for example, one, two or four counts per encoder line. Two compare values are checked against the counters and raise sticky match flags. A third sticky flag records illegal phase changes, where both tracks move in the same sampled cycle. Either match flag can be routed to a single interrupt output.

Top module: `qprc_counter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, position and revolution counts are zero, all three flags and the interrupt are low, and the direction output is high (up).
- R2: With mode 0 (quadrature), a qualified change of track A alone counts up when A differs from B after the change; a qualified change of track B alone counts up when B equals A after the change; otherwise the count goes down. The position count wraps modulo 2^POS_W.
- R3: Each edge selector uses bit 0 to enable rising edges and bit 1 to enable falling edges. An edge that is not enabled changes neither count nor direction.
- R4: With mode 1 (up/down), a qualified A edge adds one and a qualified B edge subtracts one. Both in the same cycle leave the count unchanged, and no error flag is raised in this mode.
- R5: A qualified index edge clears the position count and steps the revolution count by one in the direction shown on `dir_up` before that edge. It takes priority over a count step in the same cycle. `dir_up` follows the direction of every count step.
- R6: `pos_match` is set whenever the position count equals `pos_cmp`. It stays set until `flag_clr[0]` is high in a cycle without a match.
- R7: `rev_match` behaves the same way for the revolution count against `rev_cmp`, and is cleared by `flag_clr[1]`.
- R8: In mode 0, if both tracks change in the same sampled cycle, the position count does not change and `phase_err` is set. `flag_clr[2]` clears `phase_err`, but a new error in the same cycle wins.
- R9: `irq` is high exactly when (`pos_match` and `irq_en[0]`) or (`rev_match` and `irq_en[1]`).
- R10: A pin change made before clock edge k shows in the counts after edge k+2 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_mode | input | 1 | 0 quadrature, 1 up/down |
| a_edge_sel | input | 2 | Track A edge enable (bit0 rise, bit1 fall) |
| b_edge_sel | input | 2 | Track B edge enable (bit0 rise, bit1 fall) |
| z_edge_sel | input | 2 | Index edge enable (bit0 rise, bit1 fall) |
| pos_cmp | input | POS_W | Position compare value |
| rev_cmp | input | REV_W | Revolution compare value |
| irq_en | input | 2 | Interrupt enables: bit0 position match, bit1 revolution match |
| flag_clr | input | 3 | Clear strobes: bit0 pos_match, bit1 rev_match, bit2 phase_err |
| enc_a | input | 1 | Encoder track A pin |
| enc_b | input | 1 | Encoder track B pin |
| enc_z | input | 1 | Encoder index pin |
| pos_count | output | POS_W | Position count |
| rev_count | output | REV_W | Revolution count |
| dir_up | output | 1 | Direction of the latest count step |
| pos_match | output | 1 | Sticky position match flag |
| rev_match | output | 1 | Sticky revolution match flag |
| phase_err | output | 1 | Sticky illegal phase change flag |
| irq | output | 1 | Interrupt |

## Verification
The bench builds the block with POS_W = 4 and REV_W = 3 and keeps the default two synchroniser stages. At these widths, wrap-around in both directions for both counters occurs within a few dozen steps. Random compare values also hit often, so the sticky-flag and clear races are exercised on many cycles instead of once. The small widths leave the decoding, edge qualification and index priority unchanged, because none of that logic depends on counter width.

// File: rtl/qprc_pkg.sv
package qprc_pkg;

   typedef enum logic {
      MODE_QUAD = 1'b0,
      MODE_UPDN = 1'b1
   } cnt_mode_e;

   localparam int unsigned FLAG_POS = 0;
   localparam int unsigned FLAG_REV = 1;
   localparam int unsigned FLAG_ERR = 2;
   localparam int unsigned FLAG_N   = 3;

   // Qualified edge: the level moved and the selector enables that polarity.
   function automatic logic edge_hit(input logic [1:0] sel, input logic now, input logic was);
      return (now != was) && (now ? sel[0] : sel[1]);
   endfunction

endpackage

// File: rtl/qprc_sync.sv
module qprc_sync #(
   parameter int unsigned N_PINS = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] pin_i,
   output logic [N_PINS-1:0] lvl_o,
   output logic [N_PINS-1:0] prv_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("qprc_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < N_PINS; i++) begin : g_pin
      logic [STAGES-1:0] shf_q;
      logic              prv_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shf_q <= '0;
            prv_q <= 1'b0;
         end else begin
            shf_q <= {shf_q[STAGES-2:0], pin_i[i]};
            prv_q <= shf_q[STAGES-1];
         end
      end

      assign lvl_o[i] = shf_q[STAGES-1];
      assign prv_o[i] = prv_q;
   end

endmodule

// File: rtl/qprc_core.sv
module qprc_core
   import qprc_pkg::*;
#(
   parameter int unsigned POS_W = 16,
   parameter int unsigned REV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_i,
   input  logic [1:0]       sel_a_i,
   input  logic [1:0]       sel_b_i,
   input  logic [1:0]       sel_z_i,
   input  logic [2:0]       lvl_i,
   input  logic [2:0]       prv_i,
   output logic [POS_W-1:0] pos_o,
   output logic [REV_W-1:0] rev_o,
   output logic             dir_o,
   output logic             illegal_o
);

   localparam int unsigned IA = 0;
   localparam int unsigned IB = 1;
   localparam int unsigned IZ = 2;

   logic [POS_W-1:0] pos_q;
   logic [REV_W-1:0] rev_q;
   logic             dir_q;
   logic             a_chg, b_chg, a_hit, b_hit, z_hit;
   logic             step, step_up, illegal;

   assign a_chg = lvl_i[IA] ^ prv_i[IA];
   assign b_chg = lvl_i[IB] ^ prv_i[IB];
   assign a_hit = edge_hit(sel_a_i, lvl_i[IA], prv_i[IA]);
   assign b_hit = edge_hit(sel_b_i, lvl_i[IB], prv_i[IB]);
   assign z_hit = edge_hit(sel_z_i, lvl_i[IZ], prv_i[IZ]);

   always_comb begin
      step    = 1'b0;
      step_up = dir_q;
      illegal = 1'b0;
      if (cnt_mode_e'(mode_i) == MODE_QUAD) begin
         if (a_chg && b_chg) begin
            illegal = 1'b1;
         end else if (a_hit) begin
            step    = 1'b1;
            step_up = (lvl_i[IA] != lvl_i[IB]);
         end else if (b_hit) begin
            step    = 1'b1;
            step_up = (lvl_i[IB] == lvl_i[IA]);
         end
      end else if (a_hit != b_hit) begin
         step    = 1'b1;
         step_up = a_hit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
         rev_q <= '0;
         dir_q <= 1'b1;
      end else begin
         if (z_hit) begin
            pos_q <= '0;
            rev_q <= dir_q ? rev_q + 1'b1 : rev_q - 1'b1;
         end else if (step) begin
            pos_q <= step_up ? pos_q + 1'b1 : pos_q - 1'b1;
         end
         if (step) dir_q <= step_up;
      end
   end

   assign pos_o     = pos_q;
   assign rev_o     = rev_q;
   assign dir_o     = dir_q;
   assign illegal_o = illegal;

   AST_POS_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_q != $past(pos_q)) |-> (pos_q == POS_W'($past(pos_q) + 1'b1) ||
                                   pos_q == POS_W'($past(pos_q) - 1'b1) ||
                                   pos_q == '0));                           // R2
   AST_REV_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rev_q != $past(rev_q)) |-> (rev_q == REV_W'($past(rev_q) + 1'b1) ||
                                   rev_q == REV_W'($past(rev_q) - 1'b1)));  // R5
   AST_INDEX_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      z_hit |=> (pos_q == '0));                                            // R5
   AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (illegal && !z_hit) |=> $stable(pos_q));                             // R8

endmodule

// File: rtl/qprc_flags.sv
module qprc_flags
   import qprc_pkg::*;
#(
   parameter int unsigned POS_W = 16,
   parameter int unsigned REV_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [POS_W-1:0]  pos_i,
   input  logic [REV_W-1:0]  rev_i,
   input  logic [POS_W-1:0]  pos_cmp_i,
   input  logic [REV_W-1:0]  rev_cmp_i,
   input  logic              illegal_i,
   input  logic [FLAG_N-1:0] clr_i,
   input  logic [1:0]        irq_en_i,
   output logic [FLAG_N-1:0] flags_o,
   output logic              irq_o
);

   logic [FLAG_N-1:0] hit;
   logic [FLAG_N-1:0] flag_q;

   assign hit[FLAG_POS] = (pos_i == pos_cmp_i);
   assign hit[FLAG_REV] = (rev_i == rev_cmp_i);
   assign hit[FLAG_ERR] = illegal_i;

   for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q[i] <= 1'b0;
         else        flag_q[i] <= hit[i] | (flag_q[i] & ~clr_i[i]);
      end
   end

   assign flags_o = flag_q;
   assign irq_o   = |(flag_q[FLAG_REV:FLAG_POS] & irq_en_i);

   AST_POS_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_i == pos_cmp_i) |=> flag_q[FLAG_POS]);                          // R6
   AST_REV_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (rev_i == rev_cmp_i) |=> flag_q[FLAG_REV]);                          // R7
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[FLAG_ERR] && !clr_i[FLAG_ERR]) |=> flag_q[FLAG_ERR]);        // R8

endmodule

// File: rtl/qprc_counter.sv
module qprc_counter
   import qprc_pkg::*;
#(
   parameter int unsigned POS_W       = 16,
   parameter int unsigned REV_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_mode,
   input  logic [1:0]       a_edge_sel,
   input  logic [1:0]       b_edge_sel,
   input  logic [1:0]       z_edge_sel,
   input  logic [POS_W-1:0] pos_cmp,
   input  logic [REV_W-1:0] rev_cmp,
   input  logic [1:0]       irq_en,
   input  logic [2:0]       flag_clr,
   input  logic             enc_a,
   input  logic             enc_b,
   input  logic             enc_z,
   output logic [POS_W-1:0] pos_count,
   output logic [REV_W-1:0] rev_count,
   output logic             dir_up,
   output logic             pos_match,
   output logic             rev_match,
   output logic             phase_err,
   output logic             irq
);

   localparam int unsigned N_PINS = 3;

   if (POS_W < 2 || POS_W > 32) begin : g_bad_pos_w
      $error("qprc_counter: POS_W must lie in 2..32");
   end
   if (REV_W < 2 || REV_W > 32) begin : g_bad_rev_w
      $error("qprc_counter: REV_W must lie in 2..32");
   end

   logic [N_PINS-1:0] lvl, prv;
   logic              illegal;
   logic [FLAG_N-1:0] flags;

   qprc_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i ({enc_z, enc_b, enc_a}),
      .lvl_o (lvl),
      .prv_o (prv)
   );

   qprc_core #(.POS_W(POS_W), .REV_W(REV_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_i    (cnt_mode),
      .sel_a_i   (a_edge_sel),
      .sel_b_i   (b_edge_sel),
      .sel_z_i   (z_edge_sel),
      .lvl_i     (lvl),
      .prv_i     (prv),
      .pos_o     (pos_count),
      .rev_o     (rev_count),
      .dir_o     (dir_up),
      .illegal_o (illegal)
   );

   qprc_flags #(.POS_W(POS_W), .REV_W(REV_W)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .pos_i     (pos_count),
      .rev_i     (rev_count),
      .pos_cmp_i (pos_cmp),
      .rev_cmp_i (rev_cmp),
      .illegal_i (illegal),
      .clr_i     (flag_clr),
      .irq_en_i  (irq_en),
      .flags_o   (flags),
      .irq_o     (irq)
   );

   assign pos_match = flags[FLAG_POS];
   assign rev_match = flags[FLAG_REV];
   assign phase_err = flags[FLAG_ERR];

endmodule

// File: tb/qprc_counter_tb.sv
module qprc_counter_tb;

   localparam int PW = 4;
   localparam int RW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cnt_mode = 1'b0;
   logic [1:0]    a_sel = 2'b11, b_sel = 2'b11, z_sel = 2'b01;
   logic [PW-1:0] pos_cmp = 4'd5;
   logic [RW-1:0] rev_cmp = 3'd2;
   logic [1:0]    irq_en = 2'b00;
   logic [2:0]    flag_clr = 3'b000;
   logic          pa = 1'b0, pb = 1'b0, pz = 1'b0;
   logic [PW-1:0] pos_count;
   logic [RW-1:0] rev_count;
   logic          dir_up, pos_match, rev_match, phase_err, irq;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;
   bit  cmp_on = 1'b0;

   always #2 clk = ~clk;

   qprc_counter #(.POS_W(PW), .REV_W(RW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cnt_mode(cnt_mode),
      .a_edge_sel(a_sel), .b_edge_sel(b_sel), .z_edge_sel(z_sel),
      .pos_cmp(pos_cmp), .rev_cmp(rev_cmp), .irq_en(irq_en), .flag_clr(flag_clr),
      .enc_a(pa), .enc_b(pb), .enc_z(pz),
      .pos_count(pos_count), .rev_count(rev_count), .dir_up(dir_up),
      .pos_match(pos_match), .rev_match(rev_match), .phase_err(phase_err), .irq(irq)
   );

   // ---------------- behavioural reference ----------------
   bit [2:0]      m_d1, m_d2, m_old;   // pin history, 1 and 2 edges ago, and 3
   int            m_pos, m_rev;
   bit            m_dir, m_pf, m_rf, m_ef;

   function automatic bit qual(bit [1:0] sel, bit now, bit was);
      if (now == was) return 1'b0;
      return now ? sel[0] : sel[1];
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_d1 = '0; m_d2 = '0; m_old = '0;
         m_pos = 0; m_rev = 0; m_dir = 1'b1;
         m_pf = 1'b0; m_rf = 1'b0; m_ef = 1'b0;
      end else begin
         bit ca, cb, qa, qb, qz, stp, up, bad;
         ca = m_d2[0] != m_old[0];
         cb = m_d2[1] != m_old[1];
         qa = qual(a_sel, m_d2[0], m_old[0]);
         qb = qual(b_sel, m_d2[1], m_old[1]);
         qz = qual(z_sel, m_d2[2], m_old[2]);
         stp = 1'b0; up = m_dir; bad = 1'b0;
         if (cnt_mode == 1'b0) begin
            if (ca && cb) bad = 1'b1;
            else if (qa) begin stp = 1'b1; up = (m_d2[0] != m_d2[1]); end
            else if (qb) begin stp = 1'b1; up = (m_d2[1] == m_d2[0]); end
         end else if (qa != qb) begin
            stp = 1'b1; up = qa;
         end
         // flags look at the counts held before this edge
         m_pf = (m_pos == int'(pos_cmp)) || (m_pf && !flag_clr[0]);
         m_rf = (m_rev == int'(rev_cmp)) || (m_rf && !flag_clr[1]);
         m_ef = bad || (m_ef && !flag_clr[2]);
         if (qz) begin
            m_pos = 0;
            m_rev = (m_rev + (m_dir ? 1 : -1) + (1 << RW)) % (1 << RW);
         end else if (stp) begin
            m_pos = (m_pos + (up ? 1 : -1) + (1 << PW)) % (1 << PW);
         end
         if (stp) m_dir = up;
         m_old = m_d2; m_d2 = m_d1; m_d1 = {pz, pb, pa};
      end
   end

   task automatic check(string req, int got, int exp);
      n_vec++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, got, exp, $time);
      end
   endtask

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         check("R2 R4 R10 pos_count", int'(pos_count), m_pos);
         check("R5 rev_count", int'(rev_count), m_rev);
         check("R5 dir_up", int'(dir_up), int'(m_dir));
         check("R6 pos_match", int'(pos_match), int'(m_pf));
         check("R7 rev_match", int'(rev_match), int'(m_rf));
         check("R8 phase_err", int'(phase_err), int'(m_ef));
         check("R9 irq", int'(irq), int'((m_pf && irq_en[0]) || (m_rf && irq_en[1])));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic settle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic quad_step(bit up);
      @(negedge clk);
      if (up) begin if (pa == pb) pa = ~pa; else pb = ~pb; end
      else    begin if (pa == pb) pb = ~pb; else pa = ~pa; end
      settle(4);
   endtask

   task automatic pulse_clr(logic [2:0] v);
      @(negedge clk); flag_clr = v;
      @(negedge clk); flag_clr = 3'b000;
   endtask

   initial begin
      settle(3);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 pos", int'(pos_count), 0);
      check("R1 rev", int'(rev_count), 0);
      check("R1 dir", int'(dir_up), 1);
      check("R1 flags", int'({pos_match, rev_match, phase_err, irq}), 0);
      cmp_on = 1'b1;

      // R10 latency: A rises before edge k, count visible after edge k+2
      pa = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R10 before", int'(pos_count), 0);
      @(negedge clk);
      check("R10 after", int'(pos_count), 1);
      settle(2);

      // R2 quadrature up then down
      repeat (5) quad_step(1'b1);
      check("R2 up count", int'(pos_count), 6);
      check("R6 passed cmp", int'(pos_match), 1);
      repeat (2) quad_step(1'b0);
      check("R2 down count", int'(pos_count), 4);
      check("R2 dir down", int'(dir_up), 0);

      // R5 index rising: clear pos, rev steps down; falling ignored (R3)
      @(negedge clk); pz = 1'b1; settle(4);
      check("R5 pos cleared", int'(pos_count), 0);
      check("R5 rev stepped down", int'(rev_count), 7);
      @(negedge clk); pz = 1'b0; settle(4);
      check("R3 z fall ignored", int'(rev_count), 7);

      // R8 illegal simultaneous change
      @(negedge clk); pa = ~pa; pb = ~pb; settle(4);
      check("R8 err set", int'(phase_err), 1);
      check("R8 pos held", int'(pos_count), 0);
      pulse_clr(3'b100); settle(1);
      check("R8 err cleared", int'(phase_err), 0);

      // R3 A rising only, B disabled
      a_sel = 2'b01; b_sel = 2'b00;
      repeat (4) quad_step(1'b1);
      check("R3 rise only", int'(pos_count), 1);

      // R6 clear of position flag
      pulse_clr(3'b001); settle(1);
      check("R6 cleared", int'(pos_match), 0);

      // R4 up/down mode
      cnt_mode = 1'b1; a_sel = 2'b01; b_sel = 2'b01;
      repeat (2) begin
         @(negedge clk); pa = 1'b0; settle(4);
         @(negedge clk); pa = 1'b1; settle(4);
      end
      @(negedge clk); pb = 1'b0; settle(4);
      @(negedge clk); pb = 1'b1; settle(4);
      check("R4 up/down count", int'(pos_count), 2);
      check("R4 dir down", int'(dir_up), 0);
      @(negedge clk); pa = 1'b0; pb = 1'b0; settle(4);
      @(negedge clk); pa = 1'b1; pb = 1'b1; settle(4);
      check("R4 both cancel", int'(pos_count), 2);
      check("R4 no err", int'(phase_err), 0);

      // R7 / R9 revolution match and interrupt routing
      rev_cmp = 3'd7; irq_en = 2'b10; settle(2);
      check("R7 rev match", int'(rev_match), 1);
      check("R9 irq on", int'(irq), 1);
      irq_en = 2'b01; settle(1);
      check("R9 irq masked", int'(irq), 0);

      // random phase, reference compared every cycle
      for (int i = 0; i < 6000; i++) begin
         @(negedge clk);
         if ($urandom_range(0, 2) == 0) pa = ~pa;
         if ($urandom_range(0, 2) == 0) pb = ~pb;
         if ($urandom_range(0, 15) == 0) pz = ~pz;
         flag_clr = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000;
         if (i % 150 == 0) begin
            cnt_mode = 1'($urandom);
            a_sel = 2'($urandom); b_sel = 2'($urandom); z_sel = 2'($urandom);
            pos_cmp = PW'($urandom); rev_cmp = RW'($urandom); irq_en = 2'($urandom);
         end
      end
      settle(4);
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL R10 watchdog expired actual=hung expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule